// File: doc/BRIEF.md
# Service Period Flag Decider

Once the number of frames that fit into an upcoming frame exchange is known for each candidate bandwidth, this block decides, per bandwidth, whether every frame of that exchange must carry the end-of-service-period (EOSP) bit and whether it must carry the More Data bit. A scheduler presents one frame count per bandwidth lane together with the user's control settings and pulses a valid strobe; one cycle later the block presents registered per-lane flags and a one-cycle done strobe.

The two decisions follow different rules. The EOSP flag fires only when the frame count exactly equals its threshold. The More Data flag fires when fewer frames fit than its threshold, and only for a destination station that is in power save. Each rule has its own enable. Before either comparison, each lane's count is clamped to the maximum MPDU count. Lanes are evaluated independently, so a wide bandwidth may raise a flag that a narrower lane, carrying fewer frames, does not.

Top module: `sp_flag_decider`

## Requirements
- R1: While reset is held low at a clock edge, and after that edge, `set_eosp`, `set_more_data` and `done` are all 0.
- R2: `done` is 1 in exactly the cycle after a cycle with `req_valid` high, and 0 in every other cycle.
- R3: When `eosp_en` is 0 at a valid strobe, every bit of `set_eosp` is 0 after that strobe.
- R4: When `eosp_en` is 1 at a valid strobe, bit g of `set_eosp` is 1 after the strobe if and only if lane g's clamped count equals `eosp_thr`. A count of 0 with a threshold of 0 counts as a match.
- R5: When `more_en` is 1 and `sta_ps` is 1 (1 = station in power save) at a valid strobe, bit g of `set_more_data` is 1 after the strobe if and only if lane g's clamped count is strictly less than `more_thr`. A threshold of 0 never fires.
- R6: When `more_en` is 0, `more_thr` has no effect and every bit of `set_more_data` is 0 after the strobe.
- R7: When `sta_ps` is 0 at a valid strobe, every bit of `set_more_data` is 0 after the strobe.
- R8: A lane count above `max_frames` is treated as `max_frames` for both comparisons.
- R9: Each lane is decided only from its own count field, which is `frame_cnt[g*7 +: 7]` for lane g. Lane 0 is the narrowest bandwidth.
- R10: In a cycle without `req_valid`, both flag vectors keep the values from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Inputs are valid this cycle; a decision is taken |
| frame_cnt | input | 28 | Four 7-bit frame counts, lane g at bits g*7 +: 7 |
| max_frames | input | 7 | Maximum MPDU count used for clamping |
| eosp_en | input | 1 | Enables the EOSP decision |
| eosp_thr | input | 7 | Count that triggers EOSP on an exact match |
| more_en | input | 1 | Enables the More Data decision |
| more_thr | input | 7 | More Data fires when the count is below this value |
| sta_ps | input | 1 | Destination station power-save state, 1 = in power save |
| set_eosp | output | 4 | Per-lane request to set EOSP in all frames |
| set_more_data | output | 4 | Per-lane request to set More Data in all frames |
| done | output | 1 | One-cycle strobe: the flags hold a new decision |

## Verification
The embedded properties check the following on every cycle:
- the one-cycle relation between the strobe and `done`;
- that the flags are held between strobes;
- that the EOSP and More Data gating by the two enables and by the power-save bit holds;
- that each lane's clamped count never exceeds the maximum.

Only the bench's scenarios can show that the comparisons themselves are right: the exact-match versus strictly-less rules, their zero and saturation corners, and lanes disagreeing within one decision. For this, a behavioural reference computes the expected flags every cycle and compares them with the outputs.

// File: rtl/sfd_pkg.sv
// Package: shared defaults and the per-lane decision type for the
// service period flag decider.
package sfd_pkg;

    localparam int SFD_CNT_W  = 7;  // default frame count width
    localparam int SFD_NUM_BW = 4;  // default number of bandwidth lanes

    // Decision produced by one lane, before registering.
    typedef struct packed {
        logic eosp;
        logic more;
    } sfd_flags_t;

endpackage

// File: rtl/sfd_lane.sv
// Module: sfd_lane
// Combinational decision for one bandwidth lane. It clamps the lane's
// frame count to the maximum MPDU count. It then compares the clamped
// count with the EOSP threshold for an exact match, and with the More
// Data threshold for strictly-less.
// Assumes: every input is stable while the strobe is high; the lane
// does no registering of its own.
module sfd_lane
    import sfd_pkg::*;
#(
    parameter int CNT_W = SFD_CNT_W
) (
    input  logic [CNT_W-1:0] frame_cnt,
    input  logic [CNT_W-1:0] max_frames,
    input  logic             eosp_en,
    input  logic [CNT_W-1:0] eosp_thr,
    input  logic             more_en,
    input  logic [CNT_W-1:0] more_thr,
    input  logic             sta_ps,
    output logic [CNT_W-1:0] eff_cnt,
    output sfd_flags_t       flags
);

    // Clamp the count, then apply both threshold rules.
    always_comb begin
        eff_cnt    = (frame_cnt > max_frames) ? max_frames : frame_cnt;
        flags.eosp = eosp_en && (eff_cnt == eosp_thr);
        flags.more = more_en && sta_ps && (eff_cnt < more_thr);
    end

endmodule

// File: rtl/sfd_flag_reg.sv
// Module: sfd_flag_reg
// Output stage. It captures the per-lane decisions when the strobe is
// high, holds them otherwise, and raises done for one cycle after each
// strobe.
// Assumes: synchronous active-low reset; the decisions are valid in
// the strobe cycle.
module sfd_flag_reg
    import sfd_pkg::*;
#(
    parameter int NUM_BW = SFD_NUM_BW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [NUM_BW-1:0] nxt_eosp,
    input  logic [NUM_BW-1:0] nxt_more,
    output logic [NUM_BW-1:0] set_eosp,
    output logic [NUM_BW-1:0] set_more_data,
    output logic              done
);

    // Capture the decisions on the strobe; done follows the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_eosp      <= '0;
            set_more_data <= '0;
            done          <= 1'b0;
        end else begin
            done <= req_valid;
            if (req_valid) begin
                set_eosp      <= nxt_eosp;
                set_more_data <= nxt_more;
            end
        end
    end

    // R2: done follows the strobe by exactly one cycle.
    p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    // R2: done stays low when no strobe came.
    p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);

    // R10: the flags are held between strobes.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(set_eosp) && $stable(set_more_data)));

endmodule

// File: rtl/sp_flag_decider.sv
// Module: sp_flag_decider (top)
// Decides, for each bandwidth lane, whether EOSP and More Data must be
// set in every frame of the upcoming exchange.
// Assumes: lane g's count sits at frame_cnt[g*CNT_W +: CNT_W]; one
// set of enables and thresholds is shared by all lanes; the result
// appears one cycle after req_valid.
module sp_flag_decider
    import sfd_pkg::*;
#(
    parameter int CNT_W  = SFD_CNT_W,
    parameter int NUM_BW = SFD_NUM_BW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [NUM_BW*CNT_W-1:0] frame_cnt,
    input  logic [CNT_W-1:0]        max_frames,
    input  logic                    eosp_en,
    input  logic [CNT_W-1:0]        eosp_thr,
    input  logic                    more_en,
    input  logic [CNT_W-1:0]        more_thr,
    input  logic                    sta_ps,
    output logic [NUM_BW-1:0]       set_eosp,
    output logic [NUM_BW-1:0]       set_more_data,
    output logic                    done
);

    localparam int TOT_W = NUM_BW * CNT_W;

    logic [TOT_W-1:0]  eff_all;
    logic [NUM_BW-1:0] nxt_eosp;
    logic [NUM_BW-1:0] nxt_more;

    // One decision lane per bandwidth candidate.
    for (genvar g = 0; g < NUM_BW; g++) begin : g_lane
        sfd_flags_t lane_flags;

        sfd_lane #(.CNT_W(CNT_W)) u_lane (
            .frame_cnt (frame_cnt[g*CNT_W +: CNT_W]),
            .max_frames(max_frames),
            .eosp_en   (eosp_en),
            .eosp_thr  (eosp_thr),
            .more_en   (more_en),
            .more_thr  (more_thr),
            .sta_ps    (sta_ps),
            .eff_cnt   (eff_all[g*CNT_W +: CNT_W]),
            .flags     (lane_flags)
        );

        assign nxt_eosp[g] = lane_flags.eosp;
        assign nxt_more[g] = lane_flags.more;

        // R8: the clamped count never exceeds the maximum MPDU count.
        p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
            eff_all[g*CNT_W +: CNT_W] <= max_frames);
    end

    sfd_flag_reg #(.NUM_BW(NUM_BW)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .nxt_eosp     (nxt_eosp),
        .nxt_more     (nxt_more),
        .set_eosp     (set_eosp),
        .set_more_data(set_more_data),
        .done         (done)
    );

    // R3: a disabled EOSP check yields no EOSP request.
    p_eosp_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !eosp_en) |=> (set_eosp == '0));

    // R6: a disabled More Data check yields no More Data request.
    p_more_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !more_en) |=> (set_more_data == '0));

    // R7: a station out of power save gets no More Data request.
    p_ps_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sta_ps) |=> (set_more_data == '0));

endmodule

// File: tb/sp_flag_decider_test.sv
`timescale 1ns/1ps
module sp_flag_decider_test;

    localparam int CW = 7;
    localparam int NB = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [NB*CW-1:0] frame_cnt = '0;
    logic [CW-1:0]   max_frames = '0;
    logic            eosp_en = 1'b0;
    logic [CW-1:0]   eosp_thr = '0;
    logic            more_en = 1'b0;
    logic [CW-1:0]   more_thr = '0;
    logic            sta_ps = 1'b0;
    logic [NB-1:0]   set_eosp;
    logic [NB-1:0]   set_more_data;
    logic            done;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit finished = 0;

    // Behavioural reference state.
    int exp_eosp [NB];
    int exp_more [NB];
    int exp_done = 0;

    sp_flag_decider uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .frame_cnt(frame_cnt),
        .max_frames(max_frames), .eosp_en(eosp_en), .eosp_thr(eosp_thr),
        .more_en(more_en), .more_thr(more_thr), .sta_ps(sta_ps),
        .set_eosp(set_eosp), .set_more_data(set_more_data), .done(done)
    );

    always #2 clk = ~clk;  // 250 MHz

    // Reference model: applies the rules to the inputs at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NB; g++) begin
                exp_eosp[g] = 0;
                exp_more[g] = 0;
            end
            exp_done = 0;
        end else begin
            exp_done = req_valid ? 1 : 0;
            if (req_valid) begin
                for (int g = 0; g < NB; g++) begin
                    int c;
                    c = int'(frame_cnt[g*CW +: CW]);
                    if (c > int'(max_frames)) c = int'(max_frames);
                    exp_eosp[g] = (eosp_en && c == int'(eosp_thr)) ? 1 : 0;
                    exp_more[g] = (more_en && sta_ps && c < int'(more_thr)) ? 1 : 0;
                end
            end
        end
    end

    // Compare the outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (done !== (exp_done != 0)) begin
                errors++;
                $display("FAIL %s(R2) done actual=%b expected=%0d", cur_req, done, exp_done);
            end
            for (int g = 0; g < NB; g++) begin
                checks++;
                if (set_eosp[g] !== (exp_eosp[g] != 0) || set_more_data[g] !== (exp_more[g] != 0)) begin
                    errors++;
                    $display("FAIL %s lane %0d eosp/more actual=%b/%b expected=%0d/%0d",
                             cur_req, g, set_eosp[g], set_more_data[g], exp_eosp[g], exp_more[g]);
                end
            end
        end
    end

    function automatic logic [NB*CW-1:0] pack4(int c0, int c1, int c2, int c3);
        return {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
    endfunction

    // Issues one decision and returns after the strobe cycle.
    task automatic decide(input string req, input logic [NB*CW-1:0] cnts, input int mx,
                          input bit een, input int ethr, input bit men, input int mthr,
                          input bit ps);
        cur_req    = req;
        frame_cnt  = cnts;
        max_frames = CW'(mx);
        eosp_en    = een;
        eosp_thr   = CW'(ethr);
        more_en    = men;
        more_thr   = CW'(mthr);
        sta_ps     = ps;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        @(negedge clk);
    endtask

    // Named check of the output flags against hand-computed values.
    task automatic expect_flags(input string req, input logic [NB-1:0] e, input logic [NB-1:0] m);
        checks++;
        if (set_eosp !== e || set_more_data !== m) begin
            errors++;
            $display("FAIL %s flags actual=%b/%b expected=%b/%b", req, set_eosp, set_more_data, e, m);
        end
    endtask

    // Stimulus.
    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        expect_flags("R1", 4'b0000, 4'b0000);
        checks++;
        if (done !== 1'b0) begin
            errors++;
            $display("FAIL R1 done actual=%b expected=0", done);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3: EOSP disabled although every count matches.
        decide("R3", pack4(5, 5, 5, 5), 127, 0, 5, 0, 0, 1);
        expect_flags("R3", 4'b0000, 4'b0000);

        // R4: exact match only; R9 lanes differ.
        decide("R4", pack4(5, 3, 5, 7), 127, 1, 5, 0, 0, 1);
        expect_flags("R4", 4'b0101, 4'b0000);

        // R4: zero count against a zero threshold matches.
        decide("R4", pack4(0, 1, 0, 2), 127, 1, 0, 0, 0, 1);
        expect_flags("R4", 4'b0101, 4'b0000);

        // R5: strictly less than the threshold, station in power save.
        decide("R5", pack4(2, 4, 6, 3), 127, 0, 0, 1, 4, 1);
        expect_flags("R5", 4'b0000, 4'b1001);

        // R5: a threshold of 0 never fires.
        decide("R5", pack4(0, 0, 0, 0), 127, 0, 0, 1, 0, 1);
        expect_flags("R5", 4'b0000, 4'b0000);

        // R6: disabled More Data with the largest threshold.
        decide("R6", pack4(0, 1, 2, 3), 127, 0, 0, 0, 127, 1);
        expect_flags("R6", 4'b0000, 4'b0000);

        // R7: station awake suppresses More Data.
        decide("R7", pack4(0, 1, 2, 3), 127, 0, 0, 1, 127, 0);
        expect_flags("R7", 4'b0000, 4'b0000);

        // R8: counts above the maximum are clamped before comparing.
        decide("R8", pack4(20, 10, 127, 9), 10, 1, 10, 1, 10, 1);
        expect_flags("R8", 4'b0111, 4'b1000);

        // R9: a wide lane fires EOSP while narrower lanes carry fewer frames.
        decide("R9", pack4(3, 6, 12, 12), 127, 1, 12, 1, 12, 1);
        expect_flags("R9", 4'b1100, 4'b0011);

        // R10: flags hold through idle cycles with changing inputs.
        cur_req   = "R10";
        frame_cnt = pack4(0, 0, 0, 0);
        eosp_en   = 1'b0;
        sta_ps    = 1'b0;
        repeat (4) @(negedge clk);
        expect_flags("R10", 4'b1100, 4'b0011);

        // R2: back-to-back strobes.
        cur_req    = "R2";
        frame_cnt  = pack4(1, 2, 3, 4);
        max_frames = 7'd127;
        eosp_en    = 1'b1;
        eosp_thr   = 7'd2;
        more_en    = 1'b1;
        more_thr   = 7'd3;
        sta_ps     = 1'b1;
        req_valid  = 1'b1;
        @(negedge clk);
        eosp_thr   = 7'd4;
        @(negedge clk);
        req_valid  = 1'b0;
        @(negedge clk);
        expect_flags("R2", 4'b1000, 4'b0011);

        // R1: reset clears held flags.
        cur_req = "R1";
        rst_n = 1'b0;
        @(negedge clk);
        expect_flags("R1", 4'b0000, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule